// File: doc/BRIEF.md
# Daisy-Chained Serial Sample Transmitter

This block sends the channel samples of one sampling device out over a single serial data line with a frame sync. It also lets several identical ports be chained so that one receiver collects every device's samples. A start strobe latches up to six 16-bit samples and a channel-enable mask. The port then walks through the enabled channels in ascending order. For each channel it sends its own word first. After that it passes on as many upstream words as its device-count setting asks for, so the chain needs no address or select lines.

Ports are chained by connecting `sdo`/`sfs_out` of one port to `sdi`/`sfs_in` of the next. Only the port at the end of the chain drives the receiver. Every port in a chain must share the serial clock, the start strobe timing, the device count and the channel mask. Serial data and frame sync from upstream are sampled on the falling clock edge. They pass through a 16-stage data register and a 16-stage sync delay line, so each hop delays a word by exactly one word time. Outputs change on the rising edge.

The sequencer has three states. PH_IDLE goes to PH_LOAD on a start with a non-empty mask. PH_LOAD always goes to PH_SHIFT after one clock. PH_SHIFT stays for 16·(count+1) clocks, then goes to PH_LOAD if enabled channels remain, or back to PH_IDLE. The PH_LOAD clock is the extra serial period between channel groups: the frame sync is high and the data line is low during it.

Top module: `cascade_tx_port`

## Requirements
- R1: After reset `busy`, `sdo` and `sfs_out` are low and the device count is 0, meaning the port acts as a lone device with 16 shift clocks per channel slot.
- R2: Each word goes out MSB first, one bit per clock. The own word of a channel slot starts in the clock right after the one-clock PH_LOAD period.
- R3: Only channels whose `chan_en` bit is 1 are sent, in ascending channel index (bit i of `chan_en` selects `samples[16i+15:16i]`). A start with an all-zero mask starts nothing.
- R4: With device count D, each channel slot carries the port's own word followed by D words taken from `sdi`. For a two-port chain the last port therefore outputs last-port ch1, first-port ch1, last-port ch2, first-port ch2, and so on.
- R5: `sfs_out` is high for one clock directly before the MSB of every word: in the PH_LOAD clock for the own word, and in the last bit clock of the preceding word for relayed words. It is never high while the port is not busy.
- R6: Samples and mask are latched at the accepted start. Later changes to `samples`, and any `start` while busy, do not change the transfer.
- R7: `busy` rises in the clock after an accepted start and stays high for exactly E·(16·(D+1)+1) clocks, where E is the number of enabled channels.
- R8: A `cfg_we` write loads `cfg_dc` into the device count only while idle. A write while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sample period; latches samples and mask |
| samples | input | 96 | Six 16-bit channel samples, channel i at bits 16i+15:16i |
| chan_en | input | 6 | Channel enable mask |
| cfg_we | input | 1 | Device-count write strobe |
| cfg_dc | input | 3 | Device count value (chain length minus one) |
| sdi | input | 1 | Serial data from the upstream port |
| sfs_in | input | 1 | Frame sync from the upstream port |
| sdo | output | 1 | Serial data out |
| sfs_out | output | 1 | Frame sync out |
| busy | output | 1 | Transfer in progress |

## Verification
The bench chains two ports and checks the interleaved word order at the last port. A port that sent relayed words before its own word would swap the pairs. A port that sampled upstream data off by a clock would show every relayed word shifted by one bit. Sparse and empty channel masks expose a channel picker that skips the wrong bit or starts an empty transfer. A start strobe and a device-count write placed in the middle of a chained transfer would restart or shorten the slot in a faulty design, which shows up as wrong words and a wrong busy length. The exact busy length catches a missing or doubled extra sync clock between channel groups.

// File: rtl/cascade_tx_pkg.sv
package cascade_tx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_SHIFT = 2'd2
    } phase_e;

endpackage

// File: rtl/cascade_seq_fsm.sv
module cascade_seq_fsm
    import cascade_tx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DCW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_req,
    input  logic           any_left,
    input  logic           cfg_we,
    input  logic [DCW-1:0] cfg_dc,
    output phase_e         phase,
    output logic [DCW-1:0] dev_cnt_q,
    output logic           capture,
    output logic           take,
    output logic           busy
);

    localparam int MAX_BITS = WORD_W << DCW;
    localparam int CW       = $clog2(MAX_BITS);

    phase_e          phase_nx;
    logic [CW-1:0]   bit_cnt;
    logic [CW-1:0]   slot_end;
    logic            slot_last;

    assign slot_end  = CW'((32'(dev_cnt_q) + 1) * WORD_W - 1);
    assign slot_last = (bit_cnt == slot_end);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nx;
        end
    end

    // bit counter and device count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            dev_cnt_q <= '0;
        end else begin
            if (phase == PH_SHIFT && !slot_last) begin
                bit_cnt <= bit_cnt + 1'b1;
            end else begin
                bit_cnt <= '0;
            end
            if (cfg_we && phase == PH_IDLE) begin
                dev_cnt_q <= cfg_dc;
            end
        end
    end

    // next state
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:  if (start_req) phase_nx = PH_LOAD;
            PH_LOAD:  phase_nx = PH_SHIFT;
            PH_SHIFT: if (slot_last) phase_nx = any_left ? PH_LOAD : PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (phase != PH_IDLE);
        capture = (phase == PH_IDLE) && start_req;
        take    = (phase == PH_LOAD);
    end

endmodule

// File: rtl/cascade_sample_bank.sv
module cascade_sample_bank #(
    parameter int NCH    = 6,
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic                  take,
    input  logic [NCH*WORD_W-1:0] samples,
    input  logic [NCH-1:0]        chan_en,
    output logic [WORD_W-1:0]     own_word,
    output logic                  any_left
);

    logic [WORD_W-1:0] held [NCH];
    logic [NCH-1:0]    pending;
    logic [NCH-1:0]    low_oh;

    assign low_oh   = pending & (~pending + 1'b1);
    assign any_left = |pending;

    always_comb begin
        own_word = '0;
        for (int i = 0; i < NCH; i++) begin
            if (low_oh[i]) own_word = own_word | held[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (capture) begin
            pending <= chan_en;
        end else if (take) begin
            pending <= pending & ~low_oh;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[g] <= '0;
            end else if (capture) begin
                held[g] <= samples[g*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/cascade_link_shifter.sv
module cascade_link_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_load,
    input  logic              in_shift,
    input  logic [WORD_W-1:0] own_word,
    input  logic              sdi,
    input  logic              sfs_in,
    output logic              sdo,
    output logic              sfs_out
);

    logic              sdi_q;
    logic              sfs_q;
    logic [WORD_W-1:0] data_sr;
    logic [WORD_W-1:0] sync_dl;

    // upstream inputs are sampled on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdi_q <= 1'b0;
            sfs_q <= 1'b0;
        end else begin
            sdi_q <= sdi;
            sfs_q <= sfs_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_sr <= '0;
            sync_dl <= '0;
        end else begin
            sync_dl <= {sync_dl[WORD_W-2:0], sfs_q};
            if (in_load) begin
                data_sr <= own_word;
            end else if (in_shift) begin
                data_sr <= {data_sr[WORD_W-2:0], sdi_q};
            end
        end
    end

    assign sdo     = in_shift & data_sr[WORD_W-1];
    assign sfs_out = in_load | (in_shift & sync_dl[WORD_W-1]);

endmodule

// File: rtl/cascade_tx_port.sv
module cascade_tx_port
    import cascade_tx_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int WORD_W = 16,
    parameter int DCW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NCH*WORD_W-1:0] samples,
    input  logic [NCH-1:0]        chan_en,
    input  logic                  cfg_we,
    input  logic [DCW-1:0]        cfg_dc,
    input  logic                  sdi,
    input  logic                  sfs_in,
    output logic                  sdo,
    output logic                  sfs_out,
    output logic                  busy
);

    phase_e            phase;
    logic [DCW-1:0]    dev_cnt_q;
    logic              capture;
    logic              take;
    logic              any_left;
    logic [WORD_W-1:0] own_word;
    logic              start_req;

    assign start_req = start & (|chan_en);

    cascade_seq_fsm #(.WORD_W(WORD_W), .DCW(DCW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .any_left  (any_left),
        .cfg_we    (cfg_we),
        .cfg_dc    (cfg_dc),
        .phase     (phase),
        .dev_cnt_q (dev_cnt_q),
        .capture   (capture),
        .take      (take),
        .busy      (busy)
    );

    cascade_sample_bank #(.NCH(NCH), .WORD_W(WORD_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .take     (take),
        .samples  (samples),
        .chan_en  (chan_en),
        .own_word (own_word),
        .any_left (any_left)
    );

    cascade_link_shifter #(.WORD_W(WORD_W)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_load  (phase == PH_LOAD),
        .in_shift (phase == PH_SHIFT),
        .own_word (own_word),
        .sdi      (sdi),
        .sfs_in   (sfs_in),
        .sdo      (sdo),
        .sfs_out  (sfs_out)
    );

endmodule

// File: rtl/cascade_tx_port_chk.sv
module cascade_tx_port_chk
    import cascade_tx_pkg::*;
#(
    parameter int DCW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           sdo,
    input logic           sfs_out,
    input phase_e         phase,
    input logic [DCW-1:0] dev_cnt_q
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sdo && !sfs_out));

    // R5
    sync_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfs_out |-> busy);

    // R2
    first_clock_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sfs_out && !sdo));

    // R2
    load_then_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD) |=> (phase == PH_SHIFT));

    // R8
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dev_cnt_q));

    // R7
    end_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(phase) == PH_SHIFT));

endmodule

bind cascade_tx_port cascade_tx_port_chk #(.DCW(DCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .sdo       (sdo),
    .sfs_out   (sfs_out),
    .phase     (phase),
    .dev_cnt_q (dev_cnt_q)
);

// File: tb/cascade_tx_port_tb.sv
`timescale 1ns/1ps
module cascade_tx_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_dut = 1'b0, start_up = 1'b0;
    logic [95:0] smp_dut = '0, smp_up = '0;
    logic [5:0]  chan_en = '0;
    logic        cfg_we_dut = 1'b0, cfg_we_up = 1'b0;
    logic [2:0]  cfg_dc = '0;
    logic        up_sdo, up_sfs, sdo, sfs_out, busy, up_busy;

    int total = 0, bad = 0, busy_cnt = 0, bit_left = 0;
    logic [15:0] shw = '0;
    logic [15:0] expq [$];
    string cur_tag = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    cascade_tx_port u_up (
        .clk(clk), .rst_n(rst_n), .start(start_up), .samples(smp_up),
        .chan_en(chan_en), .cfg_we(cfg_we_up), .cfg_dc(cfg_dc),
        .sdi(1'b0), .sfs_in(1'b0), .sdo(up_sdo), .sfs_out(up_sfs), .busy(up_busy)
    );

    cascade_tx_port u_dut (
        .clk(clk), .rst_n(rst_n), .start(start_dut), .samples(smp_dut),
        .chan_en(chan_en), .cfg_we(cfg_we_dut), .cfg_dc(cfg_dc),
        .sdi(up_sdo), .sfs_in(up_sfs), .sdo(sdo), .sfs_out(sfs_out), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: frame sync marks the next 16 bits as one word
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (busy) busy_cnt++;
            if (bit_left > 0) begin
                shw = {shw[14:0], sdo};
                bit_left--;
                if (bit_left == 0) begin
                    if (expq.size() == 0) begin
                        check(1'b0, cur_tag, "unexpected word", shw, 0);
                    end else begin
                        logic [15:0] e;
                        e = expq.pop_front();
                        check(shw == e, cur_tag, "word", shw, e);
                    end
                end
            end
            if (sfs_out) begin
                // R5: a sync may only appear between words
                if (bit_left != 0) check(1'b0, "R5", "sync inside word", bit_left, 0);
                bit_left = 16;
            end
        end
    end

    function automatic logic [95:0] mk(input logic [15:0] base);
        logic [95:0] v;
        for (int i = 0; i < 6; i++) v[i*16 +: 16] = base ^ 16'(i * 16'h1357) ^ 16'(i << 12);
        return v;
    endfunction

    task automatic run_xfer(input logic [95:0] a, input logic [95:0] b,
                            input logic [5:0] m, input bit chain,
                            input bit disturb, input string tag);
        int e_cnt = 0;
        int exp_busy;
        cur_tag = tag;
        for (int c = 0; c < 6; c++) begin
            if (m[c]) begin
                e_cnt++;
                expq.push_back(a[c*16 +: 16]);
                if (chain) expq.push_back(b[c*16 +: 16]);
            end
        end
        exp_busy = e_cnt * (16 * (chain ? 2 : 1) + 1);
        @(negedge clk);
        busy_cnt = 0;
        smp_dut = a; smp_up = b; chan_en = m;
        start_dut = 1'b1; start_up = chain;
        @(negedge clk);
        start_dut = 1'b0; start_up = 1'b0;
        smp_dut = ~a; smp_up = ~b; chan_en = ~m;   // R6: changes after latch
        if (disturb) begin
            repeat (20) @(negedge clk);
            start_dut = 1'b1; cfg_we_dut = 1'b1; cfg_dc = 3'd0;   // R6, R8
            @(negedge clk);
            start_dut = 1'b0; cfg_we_dut = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(busy_cnt == exp_busy, "R7", {tag, " busy length"}, busy_cnt, exp_busy);
        check(expq.size() == 0, tag, "words missing", expq.size(), 0);
        check(bit_left == 0, "R5", "open word at end", bit_left, 0);
        expq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy at reset", busy, 0);
        check(sdo == 1'b0, "R1", "sdo at reset", sdo, 0);
        check(sfs_out == 1'b0, "R1", "sync at reset", sfs_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1, R2: default count gives lone operation
        run_xfer(mk(16'hA5C3), '0, 6'b111111, 1'b0, 1'b0, "R1 R2");
        // R3: sparse mask, ascending order
        run_xfer(mk(16'h8001), '0, 6'b100101, 1'b0, 1'b0, "R3");
        run_xfer(mk(16'hFFFF), '0, 6'b010000, 1'b0, 1'b0, "R3");

        // R3: empty mask starts nothing
        @(negedge clk);
        busy_cnt = 0; chan_en = 6'b0; start_dut = 1'b1;
        @(negedge clk);
        start_dut = 1'b0;
        repeat (5) @(negedge clk);
        check(busy_cnt == 0, "R3", "empty mask busy", busy_cnt, 0);
        check(bit_left == 0, "R3", "empty mask sync", bit_left, 0);

        // chain of two: count 1 on both
        @(negedge clk);
        cfg_dc = 3'd1; cfg_we_dut = 1'b1; cfg_we_up = 1'b1;
        @(negedge clk);
        cfg_we_dut = 1'b0; cfg_we_up = 1'b0;

        // R4, R5: interleaved order through the chain
        run_xfer(mk(16'h1234), mk(16'hBEEF), 6'b010011, 1'b1, 1'b0, "R4");
        run_xfer(mk(16'h0F0F), mk(16'hF00D), 6'b111111, 1'b1, 1'b0, "R4 R5");
        // R6, R8: start and count write mid-transfer are dropped
        run_xfer(mk(16'h7E81), mk(16'h4242), 6'b001110, 1'b1, 1'b1, "R6 R8");
        // R8: count still 1 afterwards
        run_xfer(mk(16'hC001), mk(16'h0DD5), 6'b100001, 1'b1, 1'b0, "R8");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule